// File: doc/BRIEF.md
# CBC Initialization Vector Context Guard

This block stores the 128-bit chaining value that a block-cipher engine uses in cipher-block-chaining mode. The host reaches the value as two 64-bit words on a plain register bus. The engine reports its state to the block through three inputs: the chaining mode, whether a message is in progress, and whether processing has finished. The block checks every host access against that state. An access that breaks the ordering rules leaves the stored value alone and sets a sticky error flag.

The cipher datapath reads the current value on `iv_out`. While a message is in progress, the datapath writes back each new chaining value through a dedicated update port. Message data is accepted only after the host has made a legal IV write. That write must come after reset, or after the most recent rise of the done input.

To switch context, the host waits for done, reads both words out, and later writes them back before resuming.

Top module: `cbc_iv_guard`

## Requirements
- R1: After reset the stored IV, both sticky error flags, both pulse outputs, `host_rdata` and `msg_accept` are all zero.
- R2: A host write to address 0 or 1 is legal when `cbc_mode`=1 and `busy`=0. Address 0 loads IV bits 63:0 and address 1 loads IV bits 127:64. The new value appears on `iv_out` one cycle after the write.
- R3: A host write to address 0 or 1 while `busy`=1 sets the sticky context-error flag and leaves the stored IV unchanged.
- R4: A host write to address 0 or 1 while `cbc_mode`=0 sets the sticky context-error flag and leaves the stored IV unchanged.
- R5: A host read of address 0 or 1 while `done`=0 sets the sticky early-read flag. That read returns zero on `host_rdata` one cycle later.
- R6: A host read of address 0 (bits 63:0) or address 1 (bits 127:64) while `done`=1 returns that half of the IV one cycle later. Reading both halves and writing them back restores the saved context.
- R7: A read of address 2 returns the early-read flag in bit 1 and the context-error flag in bit 0. A write to address 2 clears each flag whose bit is 1 in the written data. Status accesses never raise an error.
- R8: Each violation also produces a pulse on `err_ctx_pulse` or `err_read_pulse`. The pulse is high for exactly the cycle after the violating access.
- R9: When `upd_valid`=1 and `busy`=1, `upd_iv` replaces the whole IV on the next cycle. When `busy`=0, `upd_valid` has no effect.
- R10: `msg_accept` equals `msg_valid` once armed. The block is armed by a legal IV write and disarmed by reset and by each rising edge of `done`. A legal write in the same cycle as that edge leaves it armed.
- R11: Address 3 is unmapped. Writes to it have no effect, and reads of it return zero without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register address (0 IV low, 1 IV high, 2 status) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 64 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 64 | Registered read data, updated the cycle after a read |
| cbc_mode | input | 1 | Engine is configured for chaining mode |
| busy | input | 1 | A message is being processed |
| done | input | 1 | Processing has completed |
| upd_valid | input | 1 | Datapath offers a new chaining value |
| upd_iv | input | 128 | New chaining value from the datapath |
| msg_valid | input | 1 | Message data is offered |
| msg_accept | output | 1 | Message data is taken |
| iv_out | output | 128 | Current IV for the datapath |
| err_ctx | output | 1 | Sticky context-error flag |
| err_read | output | 1 | Sticky early-read flag |
| err_ctx_pulse | output | 1 | One-cycle context-error pulse |
| err_read_pulse | output | 1 | One-cycle early-read pulse |

## Verification
A host write of the IV and a datapath update can arrive in the same cycle while a message is busy. The bench drives both in one cycle with different values. It then expects `iv_out` to hold the update value and the context-error flag to be set, which shows the refused host write lost to the update. A second overlap is the rising edge of `done` arriving together with a legal write; that is judged by `msg_accept` staying high afterwards.

// File: rtl/cbc_iv_pkg.sv
package cbc_iv_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_IV   = 2'd1,
      ACC_STAT = 2'd2
   } acc_kind_e;

   typedef struct packed {
      logic rd;
      logic ctx;
   } err_flags_t;

endpackage

// File: rtl/cbc_iv_store.sv
module cbc_iv_store #(
   parameter int IV_W      = 128,
   parameter int DATA_W    = 64,
   parameter int NUM_WORDS = IV_W / DATA_W,
   parameter int IDX_W     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              upd_en,
   input  logic [IV_W-1:0]   upd_data,
   output logic [IV_W-1:0]   iv
);

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(w);
      logic [DATA_W-1:0] word_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (upd_en) begin
            word_q <= upd_data[w*DATA_W +: DATA_W];
         end else if (wr_en && (wr_idx == MY_IDX)) begin
            word_q <= wr_data;
         end
      end

      assign iv[w*DATA_W +: DATA_W] = word_q;
   end

endmodule

// File: rtl/cbc_iv_rule.sv
module cbc_iv_rule
   import cbc_iv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  acc_kind_e  kind,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic [1:0] clr_mask,
   input  logic       cbc_mode,
   input  logic       busy,
   input  logic       done,
   output logic       wr_ok,
   output logic       rd_ok,
   output err_flags_t flags,
   output err_flags_t pulses,
   output logic       armed
);

   logic iv_hit;
   logic st_wr;
   logic wr_bad;
   logic rd_bad;
   logic done_q;
   logic done_rise;
   err_flags_t flags_q;
   err_flags_t pulses_q;
   logic armed_q;

   assign iv_hit    = (kind == ACC_IV);
   assign st_wr     = host_wr && (kind == ACC_STAT);
   assign wr_ok     = host_wr && iv_hit && cbc_mode && !busy;
   assign wr_bad    = host_wr && iv_hit && (busy || !cbc_mode);
   assign rd_ok     = host_rd && iv_hit && done;
   assign rd_bad    = host_rd && iv_hit && !done;
   assign done_rise = done && !done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q  <= '0;
         pulses_q <= '0;
         done_q   <= 1'b0;
         armed_q  <= 1'b0;
      end else begin
         flags_q.ctx  <= wr_bad || (flags_q.ctx && !(st_wr && clr_mask[0]));
         flags_q.rd   <= rd_bad || (flags_q.rd && !(st_wr && clr_mask[1]));
         pulses_q.ctx <= wr_bad;
         pulses_q.rd  <= rd_bad;
         done_q       <= done;
         if (wr_ok) begin
            armed_q <= 1'b1;
         end else if (done_rise) begin
            armed_q <= 1'b0;
         end
      end
   end

   assign flags  = flags_q;
   assign pulses = pulses_q;
   assign armed  = armed_q;

endmodule

// File: rtl/cbc_iv_rdmux.sv
module cbc_iv_rdmux
   import cbc_iv_pkg::*;
#(
   parameter int IV_W      = 128,
   parameter int DATA_W    = 64,
   parameter int NUM_WORDS = IV_W / DATA_W,
   parameter int IDX_W     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rd,
   input  acc_kind_e         kind,
   input  logic [IDX_W-1:0]  idx,
   input  logic              rd_ok,
   input  logic [IV_W-1:0]   iv,
   input  err_flags_t        flags,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] words [NUM_WORDS];
   logic [DATA_W-1:0] next_data;
   logic [DATA_W-1:0] rdata_q;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_split
      assign words[w] = iv[w*DATA_W +: DATA_W];
   end

   always_comb begin
      next_data = '0;
      if (kind == ACC_STAT) begin
         next_data[1:0] = flags;
      end else if (rd_ok) begin
         next_data = words[idx];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (host_rd) begin
         rdata_q <= next_data;
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/cbc_iv_guard.sv
module cbc_iv_guard
   import cbc_iv_pkg::*;
#(
   parameter int IV_W   = 128,
   parameter int DATA_W = 64,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              cbc_mode,
   input  logic              busy,
   input  logic              done,
   input  logic              upd_valid,
   input  logic [IV_W-1:0]   upd_iv,
   input  logic              msg_valid,
   output logic              msg_accept,
   output logic [IV_W-1:0]   iv_out,
   output logic              err_ctx,
   output logic              err_read,
   output logic              err_ctx_pulse,
   output logic              err_read_pulse
);

   localparam int NUM_WORDS = IV_W / DATA_W;
   localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_WORDS);

   if (IV_W % DATA_W != 0) begin : g_bad_split
      $fatal(1, "IV_W must be a multiple of DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $fatal(1, "DATA_W must hold the two status bits");
   end
   if ((1 << ADDR_W) <= NUM_WORDS) begin : g_bad_addr
      $fatal(1, "ADDR_W too small for IV words plus status");
   end
   if (IDX_W > ADDR_W) begin : g_bad_idx
      $fatal(1, "IDX_W exceeds ADDR_W");
   end

   acc_kind_e  kind;
   logic       wr_ok;
   logic       rd_ok;
   logic       armed;
   logic       upd_en;
   err_flags_t flags;
   err_flags_t pulses;

   always_comb begin
      if (host_addr < STAT_ADDR) begin
         kind = ACC_IV;
      end else if (host_addr == STAT_ADDR) begin
         kind = ACC_STAT;
      end else begin
         kind = ACC_NONE;
      end
   end

   assign upd_en = upd_valid && busy;

   cbc_iv_rule u_rule (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .host_wr  (host_wr),
      .host_rd  (host_rd),
      .clr_mask (host_wdata[1:0]),
      .cbc_mode (cbc_mode),
      .busy     (busy),
      .done     (done),
      .wr_ok    (wr_ok),
      .rd_ok    (rd_ok),
      .flags    (flags),
      .pulses   (pulses),
      .armed    (armed)
   );

   cbc_iv_store #(
      .IV_W      (IV_W),
      .DATA_W    (DATA_W),
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok),
      .wr_idx   (host_addr[IDX_W-1:0]),
      .wr_data  (host_wdata),
      .upd_en   (upd_en),
      .upd_data (upd_iv),
      .iv       (iv_out)
   );

   cbc_iv_rdmux #(
      .IV_W      (IV_W),
      .DATA_W    (DATA_W),
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W)
   ) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .host_rd (host_rd),
      .kind    (kind),
      .idx     (host_addr[IDX_W-1:0]),
      .rd_ok   (rd_ok),
      .iv      (iv_out),
      .flags   (flags),
      .rdata   (host_rdata)
   );

   assign msg_accept     = msg_valid && armed;
   assign err_ctx        = flags.ctx;
   assign err_read       = flags.rd;
   assign err_ctx_pulse  = pulses.ctx;
   assign err_read_pulse = pulses.rd;

endmodule

// File: rtl/cbc_iv_guard_chk.sv
module cbc_iv_guard_chk #(
   parameter int IV_W   = 128,
   parameter int DATA_W = 64,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic [DATA_W-1:0] host_rdata,
   input logic              cbc_mode,
   input logic              busy,
   input logic              done,
   input logic              upd_valid,
   input logic              msg_valid,
   input logic              msg_accept,
   input logic [IV_W-1:0]   iv_out,
   input logic              err_ctx,
   input logic              err_read,
   input logic              err_ctx_pulse,
   input logic              err_read_pulse
);

   localparam logic [ADDR_W-1:0] WORDS = ADDR_W'(IV_W / DATA_W);

   logic iv_addr;
   assign iv_addr = host_addr < WORDS;

   AST_BUSY_WR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && iv_addr && busy && !upd_valid |=> $stable(iv_out)); // R3
   AST_BUSY_WR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && iv_addr && busy |=> err_ctx && err_ctx_pulse); // R3
   AST_MODE_WR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && iv_addr && !cbc_mode && !busy |=> $stable(iv_out) && err_ctx); // R4
   AST_EARLY_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && iv_addr && !done |=> host_rdata == '0 && err_read); // R5
   AST_PULSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ctx_pulse -> err_ctx) && (err_read_pulse -> err_read)); // R8
   AST_IDLE_UPD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && !busy && !host_wr |=> $stable(iv_out)); // R9
   AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      msg_accept |-> msg_valid); // R10
   AST_DONE_RISE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) && !host_wr |=> !msg_accept); // R10

endmodule

bind cbc_iv_guard cbc_iv_guard_chk #(
   .IV_W   (IV_W),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .host_addr      (host_addr),
   .host_wr        (host_wr),
   .host_rd        (host_rd),
   .host_rdata     (host_rdata),
   .cbc_mode       (cbc_mode),
   .busy           (busy),
   .done           (done),
   .upd_valid      (upd_valid),
   .msg_valid      (msg_valid),
   .msg_accept     (msg_accept),
   .iv_out         (iv_out),
   .err_ctx        (err_ctx),
   .err_read       (err_read),
   .err_ctx_pulse  (err_ctx_pulse),
   .err_read_pulse (err_read_pulse)
);

// File: tb/cbc_iv_guard_tb.sv
module cbc_iv_guard_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   host_addr = '0;
   logic         host_wr = 1'b0;
   logic [63:0]  host_wdata = '0;
   logic         host_rd = 1'b0;
   logic [63:0]  host_rdata;
   logic         cbc_mode = 1'b0;
   logic         busy = 1'b0;
   logic         done = 1'b0;
   logic         upd_valid = 1'b0;
   logic [127:0] upd_iv = '0;
   logic         msg_valid = 1'b0;
   logic         msg_accept;
   logic [127:0] iv_out;
   logic         err_ctx;
   logic         err_read;
   logic         err_ctx_pulse;
   logic         err_read_pulse;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   cbc_iv_guard u_dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
      .cbc_mode(cbc_mode), .busy(busy), .done(done), .upd_valid(upd_valid),
      .upd_iv(upd_iv), .msg_valid(msg_valid), .msg_accept(msg_accept),
      .iv_out(iv_out), .err_ctx(err_ctx), .err_read(err_read),
      .err_ctx_pulse(err_ctx_pulse), .err_read_pulse(err_read_pulse)
   );

   localparam logic [63:0] VA = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] VB = 64'hFEDC_BA98_7654_3210;

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic [1:0]  addr;
      logic [63:0] data;
      logic        cbc;
      logic        bsy;
      logic        dn;
      logic        chk_rd;
      logic [63:0] exp_rd;
      logic [1:0]  exp_err;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 2'd0, VA,         1'b1, 1'b0, 1'b0, 1'b0, 64'd0, 2'b00}, // R2 low
      '{1'b1, 1'b0, 2'd1, VB,         1'b1, 1'b0, 1'b0, 1'b0, 64'd0, 2'b00}, // R2 high
      '{1'b0, 1'b1, 2'd0, 64'd0,      1'b1, 1'b0, 1'b1, 1'b1, VA,    2'b00}, // R6 low
      '{1'b0, 1'b1, 2'd1, 64'd0,      1'b1, 1'b0, 1'b1, 1'b1, VB,    2'b00}, // R6 high
      '{1'b1, 1'b0, 2'd0, 64'h5555,   1'b1, 1'b1, 1'b1, 1'b0, 64'd0, 2'b01}, // R3
      '{1'b0, 1'b1, 2'd0, 64'd0,      1'b1, 1'b0, 1'b1, 1'b1, VA,    2'b01}, // R3 hold
      '{1'b1, 1'b0, 2'd2, 64'd1,      1'b1, 1'b0, 1'b1, 1'b0, 64'd0, 2'b00}, // R7 clear
      '{1'b1, 1'b0, 2'd1, 64'h7777,   1'b0, 1'b0, 1'b1, 1'b0, 64'd0, 2'b01}, // R4
      '{1'b0, 1'b1, 2'd1, 64'd0,      1'b0, 1'b0, 1'b1, 1'b1, VB,    2'b01}, // R4 hold
      '{1'b0, 1'b1, 2'd0, 64'd0,      1'b1, 1'b0, 1'b0, 1'b1, 64'd0, 2'b11}, // R5
      '{1'b0, 1'b1, 2'd2, 64'd0,      1'b1, 1'b0, 1'b0, 1'b1, 64'd3, 2'b11}, // R7 status
      '{1'b1, 1'b0, 2'd2, 64'd2,      1'b1, 1'b0, 1'b0, 1'b0, 64'd0, 2'b01}, // R7 clr rd
      '{1'b1, 1'b0, 2'd2, 64'd1,      1'b1, 1'b0, 1'b0, 1'b0, 64'd0, 2'b00}, // R7 clr ctx
      '{1'b1, 1'b0, 2'd3, 64'h9999,   1'b1, 1'b0, 1'b0, 1'b0, 64'd0, 2'b00}, // R11 wr
      '{1'b0, 1'b1, 2'd3, 64'd0,      1'b1, 1'b0, 1'b0, 1'b1, 64'd0, 2'b00}  // R11 rd
   };

   task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
   task automatic host_op(input logic wr, input logic rd, input logic [1:0] a,
                          input logic [63:0] d);
      host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
      @(posedge clk);
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] lo_save;
      logic [63:0] hi_save;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      msg_valid = 1'b1;
      #1;
      check(iv_out, 128'd0, "R1 iv");
      check({126'd0, err_read, err_ctx}, 128'd0, "R1 flags");
      check({126'd0, err_read_pulse, err_ctx_pulse}, 128'd0, "R1 pulses");
      check(host_rdata, 64'd0, "R1 rdata");
      check(msg_accept, 1'b0, "R1 accept");
      msg_valid = 1'b0;

      for (int i = 0; i < NV; i++) begin
         cbc_mode = VECS[i].cbc; busy = VECS[i].bsy; done = VECS[i].dn;
         host_op(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].data);
         check({err_read, err_ctx}, VECS[i].exp_err, $sformatf("vec%0d flags R3 R4 R5 R7", i));
         if (VECS[i].chk_rd) check(host_rdata, VECS[i].exp_rd, $sformatf("vec%0d rdata R6 R11", i));
      end
      check(iv_out, {VB, VA}, "R11 iv untouched");

      // R8 pulse width
      cbc_mode = 1'b1; busy = 1'b1; done = 1'b0;
      host_op(1'b1, 1'b0, 2'd0, 64'h1);
      check(err_ctx_pulse, 1'b1, "R8 ctx pulse high");
      @(negedge clk);
      check(err_ctx_pulse, 1'b0, "R8 ctx pulse low");
      check(err_ctx, 1'b1, "R8 ctx sticky");
      busy = 1'b0;
      host_op(1'b1, 1'b0, 2'd0, 64'h0000_0000_0000_0000 | VA);
      host_op(1'b0, 1'b1, 2'd1, 64'd0);
      check(err_read_pulse, 1'b1, "R8 rd pulse high");
      @(negedge clk);
      check(err_read_pulse, 1'b0, "R8 rd pulse low");
      host_op(1'b1, 1'b0, 2'd2, 64'd3);
      check({err_read, err_ctx}, 2'b00, "R7 clear both");

      // R9 update port
      busy = 1'b1; upd_valid = 1'b1; upd_iv = {VA, VB};
      @(posedge clk); @(negedge clk);
      check(iv_out, {VA, VB}, "R9 update while busy");
      busy = 1'b0; upd_iv = 128'h1111;
      @(posedge clk); @(negedge clk);
      check(iv_out, {VA, VB}, "R9 update ignored idle");
      // Collision: host write and update in one busy cycle
      busy = 1'b1; upd_iv = {2{64'hCAFE_F00D_1234_5678}};
      host_op(1'b1, 1'b0, 2'd0, 64'hDEAD);
      check(iv_out, {2{64'hCAFE_F00D_1234_5678}}, "R9 R3 update beats host write");
      check(err_ctx, 1'b1, "R3 collision error");
      upd_valid = 1'b0; busy = 1'b0;
      host_op(1'b1, 1'b0, 2'd2, 64'd1);

      // R6 context save and restore
      done = 1'b1;
      host_op(1'b0, 1'b1, 2'd0, 64'd0); lo_save = host_rdata;
      host_op(1'b0, 1'b1, 2'd1, 64'd0); hi_save = host_rdata;
      busy = 1'b1; upd_valid = 1'b1; upd_iv = 128'h5A5A;
      @(posedge clk); @(negedge clk);
      upd_valid = 1'b0; busy = 1'b0;
      host_op(1'b1, 1'b0, 2'd0, lo_save);
      host_op(1'b1, 1'b0, 2'd1, hi_save);
      check(iv_out, {2{64'hCAFE_F00D_1234_5678}}, "R6 R2 context restored");

      // R10 arming
      done = 1'b0;
      @(negedge clk);
      msg_valid = 1'b1; #1;
      check(msg_accept, 1'b1, "R10 armed by legal write");
      msg_valid = 1'b0; #1;
      check(msg_accept, 1'b0, "R10 follows msg_valid");
      done = 1'b1;
      @(posedge clk); @(negedge clk);
      msg_valid = 1'b1; #1;
      check(msg_accept, 1'b0, "R10 disarmed by done rise");
      host_op(1'b1, 1'b0, 2'd0, VA);
      check(msg_accept, 1'b1, "R10 rearmed while done high");
      done = 1'b0;
      @(negedge clk);
      done = 1'b1;
      host_op(1'b1, 1'b0, 2'd1, VB);
      check(msg_accept, 1'b1, "R10 write beats done rise");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule